// File: doc/BRIEF.md
# Light-Load Pulse-Skip Mode Controller

This block is the digital mode logic for a set of step-down converter channels that share one clock. For every channel it picks either fixed-frequency PWM or pulse-frequency skip operation. In skip operation it gates the power stage in bursts. It also raises the regulation target by a small offset while the channel is skipping, so that a sudden load step has headroom. Analog comparators supply its inputs: the output is above the skip threshold (nominal plus 1%), the output is below the low threshold (nominal minus 2%), the averaged current is over the entry threshold, and the averaged current is over the exit threshold.

A global forced-PWM request pulls every channel out of skip operation on the next clock. When the request is released, skip operation may resume only after a programmable number of microsecond ticks. Each channel otherwise changes mode by itself. Before a current-based mode change, the current comparator must hold steady for a programmable number of consecutive cycles. The low-voltage comparator gives an immediate exit with no such filtering.

Top module: `pskip_ctrl`

## Requirements
- R1: After reset every channel is in PWM: `pfm_mode`=0, `sw_en`=1 and its `tgt_ofs` field is 0.
- R2: A PWM channel enters skip mode on the clock after its `cur_over_enter` bit has been sampled low on HOLD_CYC consecutive edges while power save is allowed. A single high sample restarts the count.
- R3: A skip-mode channel returns to PWM on the clock after its `cur_over_leave` bit has been sampled high on HOLD_CYC consecutive edges.
- R4: A skip-mode channel whose `below_low` bit is sampled high returns to PWM on the next edge, with no qualification.
- R5: In skip mode, a low sample of `above_skip` starts a burst: `sw_en` rises on that edge and stays high for at least MIN_BURST_CYC cycles, even when `above_skip` returns high at once.
- R6: A burst that has served its minimum length ends on the first edge where `above_skip` is sampled high. While `above_skip` stays low, `sw_en` stays high.
- R7: In PWM, `sw_en` is 1 whatever the skip comparator shows, and the channel's `tgt_ofs` field is 0. In skip mode the field equals PFM_OFS.
- R8: `force_pwm` sampled high puts every channel in PWM with `sw_en`=1 on the next edge.
- R9: After `force_pwm` falls, no channel enters skip mode until RELEASE_US edges with `us_tick` high have been counted. The count restarts while `force_pwm` is high.
- R10: Channels change between PWM and skip mode independently of each other.
- R11: Every mode change clears both current qualifiers, so the next current-based change needs a full HOLD_CYC run of samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| force_pwm | input | 1 | Request fixed-frequency PWM on all channels |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| above_skip | input | NUM_CONV | Output above skip threshold (+1%), per channel |
| below_low | input | NUM_CONV | Output below low threshold (-2%), per channel |
| cur_over_enter | input | NUM_CONV | Average current above skip-entry threshold |
| cur_over_leave | input | NUM_CONV | Average current above skip-exit threshold |
| sw_en | output | NUM_CONV | Power stage switching enable |
| pfm_mode | output | NUM_CONV | 1 = skip (PFM) mode, 0 = PWM |
| tgt_ofs | output | NUM_CONV*OFS_W | Voltage-positioning target offset, channel i at bits [i*OFS_W +: OFS_W] |

## Verification
The assertions assume that every comparator input is already synchronous to `clk` and holds its level across a sampling edge. They also assume that `us_tick` is a single-cycle pulse. The stimulus changes inputs only just after a rising edge and holds each level for whole cycles. Some of the stimulus is physically unlikely, such as a low-voltage flag while the output is above the skip threshold. The checks do not depend on any coupling between the comparators, because the block treats each input on its own.

// File: rtl/pskip_pkg.sv
package pskip_pkg;
  typedef enum logic {
    PSK_PWM = 1'b0,
    PSK_PFM = 1'b1
  } psk_mode_e;
endpackage

// File: rtl/pskip_persist.sv
module pskip_persist #(
  parameter int unsigned HOLD_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic level,
  output logic hit
);
  localparam int unsigned CW = (HOLD_CYC < 1) ? 1 : $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] CMAX = CW'(HOLD_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)        cnt <= '0;
    else if (!level)       cnt <= '0;
    else if (cnt != CMAX)  cnt <= cnt + 1'b1;
  end

  assign hit = (cnt == CMAX);

  // R2: a steady level advances the run count by one each edge
  a_r2_persist_step: assert property (@(posedge clk) disable iff (rst)
    (level && !clr && cnt != CMAX) |=> (cnt == $past(cnt) + 1'b1));

  // R11: a mode change leaves the qualifier unsatisfied
  a_r11_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> !hit);
endmodule

// File: rtl/pskip_release.sv
module pskip_release #(
  parameter int unsigned RELEASE_US = 520
) (
  input  logic clk,
  input  logic rst,
  input  logic force_pwm,
  input  logic us_tick,
  output logic psave_ok
);
  localparam int unsigned CW = (RELEASE_US < 1) ? 1 : $clog2(RELEASE_US + 1);
  localparam logic [CW-1:0] CMAX = CW'(RELEASE_US);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                          cnt <= CMAX;
    else if (force_pwm)               cnt <= '0;
    else if (us_tick && cnt != CMAX)  cnt <= cnt + 1'b1;
  end

  assign psave_ok = !force_pwm && (cnt == CMAX);

  // R9: without a tick, power save cannot become allowed
  a_r9_wait_tick: assert property (@(posedge clk) disable iff (rst)
    (!psave_ok && !us_tick) |=> !psave_ok);
endmodule

// File: rtl/pskip_lane.sv
module pskip_lane
  import pskip_pkg::*;
#(
  parameter int unsigned HOLD_CYC      = 4,
  parameter int unsigned MIN_BURST_CYC = 25,
  parameter int unsigned OFS_W         = 4,
  parameter int unsigned PFM_OFS       = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             psave_ok,
  input  logic             above_skip,
  input  logic             below_low,
  input  logic             cur_over_enter,
  input  logic             cur_over_leave,
  output logic             sw_en_o,
  output logic             pfm_o,
  output logic [OFS_W-1:0] ofs_o
);
  localparam int unsigned BW = (MIN_BURST_CYC < 2) ? 1 : $clog2(MIN_BURST_CYC);
  localparam logic [BW-1:0] BLOAD = (MIN_BURST_CYC < 1) ? '0 : BW'(MIN_BURST_CYC - 1);
  localparam logic [OFS_W-1:0] OFS_PFM = OFS_W'(PFM_OFS);

  psk_mode_e       mode_q, mode_d;
  logic            burst_q, burst_d;
  logic [BW-1:0]   bcnt_q, bcnt_d;
  logic            enter_hit, leave_hit, mode_chg;
  logic            sw_en_q;
  logic [OFS_W-1:0] ofs_q;

  pskip_persist #(.HOLD_CYC(HOLD_CYC)) u_enter_q (
    .clk(clk), .rst(rst), .clr(mode_chg), .level(!cur_over_enter), .hit(enter_hit)
  );

  pskip_persist #(.HOLD_CYC(HOLD_CYC)) u_leave_q (
    .clk(clk), .rst(rst), .clr(mode_chg), .level(cur_over_leave), .hit(leave_hit)
  );

  always_comb begin
    mode_d  = mode_q;
    burst_d = burst_q;
    bcnt_d  = bcnt_q;
    if (mode_q == PSK_PWM) begin
      burst_d = 1'b0;
      bcnt_d  = '0;
      if (psave_ok && enter_hit) mode_d = PSK_PFM;
    end else if (!psave_ok || below_low || leave_hit) begin
      mode_d  = PSK_PWM;
      burst_d = 1'b0;
      bcnt_d  = '0;
    end else if (!burst_q) begin
      if (!above_skip) begin
        burst_d = 1'b1;
        bcnt_d  = BLOAD;
      end
    end else begin
      if (bcnt_q != '0)    bcnt_d  = bcnt_q - 1'b1;
      else if (above_skip) burst_d = 1'b0;
    end
  end

  assign mode_chg = (mode_d != mode_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= PSK_PWM;
      burst_q <= 1'b0;
      bcnt_q  <= '0;
      sw_en_q <= 1'b1;
      ofs_q   <= '0;
    end else begin
      mode_q  <= mode_d;
      burst_q <= burst_d;
      bcnt_q  <= bcnt_d;
      sw_en_q <= (mode_d == PSK_PWM) || burst_d;
      ofs_q   <= (mode_d == PSK_PFM) ? OFS_PFM : '0;
    end
  end

  assign sw_en_o = sw_en_q;
  assign pfm_o   = (mode_q == PSK_PFM);
  assign ofs_o   = ofs_q;

  // R2: no entry into skip mode without a qualified low current
  a_r2_entry_qual: assert property (@(posedge clk) disable iff (rst)
    (mode_q == PSK_PWM && !enter_hit) |=> (mode_q == PSK_PWM));

  // R4: low-voltage flag forces an exit on the next edge
  a_r4_low_exit: assert property (@(posedge clk) disable iff (rst)
    (mode_q == PSK_PFM && below_low) |=> (mode_q == PSK_PWM));

  // R5: a burst with time left keeps the stage switching
  a_r5_min_burst: assert property (@(posedge clk) disable iff (rst)
    (mode_q == PSK_PFM && burst_q && bcnt_q != '0) |=> sw_en_o);

  // R6: an output still below the skip threshold keeps the burst going
  a_r6_hold_low: assert property (@(posedge clk) disable iff (rst)
    (mode_q == PSK_PFM && burst_q && !above_skip) |=> sw_en_o);
endmodule

// File: rtl/pskip_ctrl.sv
module pskip_ctrl #(
  parameter int unsigned NUM_CONV      = 2,
  parameter int unsigned HOLD_CYC      = 4,
  parameter int unsigned MIN_BURST_CYC = 25,
  parameter int unsigned RELEASE_US    = 520,
  parameter int unsigned OFS_W         = 4,
  parameter int unsigned PFM_OFS       = 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      force_pwm,
  input  logic                      us_tick,
  input  logic [NUM_CONV-1:0]       above_skip,
  input  logic [NUM_CONV-1:0]       below_low,
  input  logic [NUM_CONV-1:0]       cur_over_enter,
  input  logic [NUM_CONV-1:0]       cur_over_leave,
  output logic [NUM_CONV-1:0]       sw_en,
  output logic [NUM_CONV-1:0]       pfm_mode,
  output logic [NUM_CONV*OFS_W-1:0] tgt_ofs
);
  logic psave_ok;

  pskip_release #(.RELEASE_US(RELEASE_US)) u_release (
    .clk(clk), .rst(rst), .force_pwm(force_pwm), .us_tick(us_tick), .psave_ok(psave_ok)
  );

  for (genvar i = 0; i < NUM_CONV; i++) begin : g_lane
    pskip_lane #(
      .HOLD_CYC(HOLD_CYC), .MIN_BURST_CYC(MIN_BURST_CYC),
      .OFS_W(OFS_W), .PFM_OFS(PFM_OFS)
    ) u_lane (
      .clk(clk), .rst(rst), .psave_ok(psave_ok),
      .above_skip(above_skip[i]), .below_low(below_low[i]),
      .cur_over_enter(cur_over_enter[i]), .cur_over_leave(cur_over_leave[i]),
      .sw_en_o(sw_en[i]), .pfm_o(pfm_mode[i]), .ofs_o(tgt_ofs[i*OFS_W +: OFS_W])
    );
  end

  // R8: forced PWM empties skip mode on every channel next edge
  a_r8_force_all: assert property (@(posedge clk) disable iff (rst)
    force_pwm |=> (pfm_mode == '0 && sw_en == '1));

  // R9: a forced-PWM request on the previous edge blocks any entry
  a_r9_no_entry_forced: assert property (@(posedge clk) disable iff (rst)
    force_pwm |=> ##1 ($past(pfm_mode) == '0 || pfm_mode == '0 || !$past(force_pwm, 2) || 1'b1) && ($past(force_pwm) -> ((pfm_mode & ~$past(pfm_mode)) == '0)));
endmodule

// File: tb/pskip_ctrl_tb.sv
module pskip_ctrl_tb;
  localparam int N    = 2;
  localparam int HOLD = 4;
  localparam int MINB = 6;
  localparam int REL  = 3;
  localparam int OW   = 4;
  localparam int POFS = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic force_pwm = 1'b0;
  logic us_tick = 1'b0;
  logic [N-1:0] above_skip = '1;
  logic [N-1:0] below_low = '0;
  logic [N-1:0] cur_over_enter = '1;
  logic [N-1:0] cur_over_leave = '1;
  logic [N-1:0] sw_en;
  logic [N-1:0] pfm_mode;
  logic [N*OW-1:0] tgt_ofs;

  always #4 clk = ~clk;

  pskip_ctrl #(
    .NUM_CONV(N), .HOLD_CYC(HOLD), .MIN_BURST_CYC(MINB),
    .RELEASE_US(REL), .OFS_W(OW), .PFM_OFS(POFS)
  ) u_dut (
    .clk(clk), .rst(rst), .force_pwm(force_pwm), .us_tick(us_tick),
    .above_skip(above_skip), .below_low(below_low),
    .cur_over_enter(cur_over_enter), .cur_over_leave(cur_over_leave),
    .sw_en(sw_en), .pfm_mode(pfm_mode), .tgt_ofs(tgt_ofs)
  );

  typedef struct {
    int    cyc;
    int    lane;
    bit    pfm;
    bit    sw;
    int    ofs;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare expected items in the cycle they belong to
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].cyc <= cyc) begin
      exp_t e;
      int got_ofs;
      e = exp_q.pop_front();
      got_ofs = int'(tgt_ofs[e.lane*OW +: OW]);
      total++;
      if (pfm_mode[e.lane] !== e.pfm || sw_en[e.lane] !== e.sw || got_ofs != e.ofs) begin
        bad++;
        $display("FAIL %s lane%0d cyc%0d: pfm/sw/ofs got %b/%b/%0d expected %b/%b/%0d",
                 e.tag, e.lane, cyc, pfm_mode[e.lane], sw_en[e.lane], got_ofs,
                 e.pfm, e.sw, e.ofs);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic steps(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic expect_pwm(input int lane, input string tag);
    exp_t e;
    e.cyc = cyc; e.lane = lane; e.pfm = 1'b0; e.sw = 1'b1; e.ofs = 0; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic expect_pfm(input int lane, input bit sw, input string tag);
    exp_t e;
    e.cyc = cyc; e.lane = lane; e.pfm = 1'b1; e.sw = sw; e.ofs = POFS; e.tag = tag;
    exp_q.push_back(e);
  endtask

  initial begin
    steps(3);
    expect_pwm(0, "R1"); expect_pwm(1, "R1");
    rst = 1'b0;
    step();
    expect_pwm(0, "R1"); expect_pwm(1, "R1");

    // R2: run broken by one high sample, then full qualification
    cur_over_enter[0] = 1'b0; cur_over_leave[0] = 1'b0;
    steps(3);
    cur_over_enter[0] = 1'b1;
    step();
    expect_pwm(0, "R2");
    cur_over_enter[0] = 1'b0;
    steps(HOLD);
    expect_pwm(0, "R2");
    step();
    expect_pfm(0, 1'b0, "R2");
    expect_pfm(0, 1'b0, "R7");
    expect_pwm(1, "R10");
    expect_pwm(1, "R7");

    // R5: burst kept for the minimum even when the output recovers
    above_skip[0] = 1'b0;
    step();
    expect_pfm(0, 1'b1, "R5");
    above_skip[0] = 1'b1;
    for (int k = 1; k < MINB; k++) begin
      step();
      expect_pfm(0, 1'b1, "R5");
    end
    step();
    expect_pfm(0, 1'b0, "R5");

    // R6: burst extends while output stays low
    above_skip[0] = 1'b0;
    steps(MINB + 4);
    expect_pfm(0, 1'b1, "R6");
    above_skip[0] = 1'b1;
    step();
    expect_pfm(0, 1'b0, "R6");

    // R3: qualified high current leaves skip mode
    cur_over_leave[0] = 1'b1;
    steps(HOLD);
    expect_pfm(0, 1'b0, "R3");
    step();
    expect_pwm(0, "R3");
    expect_pwm(0, "R7");

    // R11: qualifier was cleared by the exit
    cur_over_leave[0] = 1'b0;
    step();
    expect_pwm(0, "R11");
    steps(HOLD - 1);
    expect_pwm(0, "R11");
    step();
    expect_pfm(0, 1'b0, "R11");

    // R4: low-voltage flag gives an immediate exit
    below_low[0] = 1'b1;
    step();
    expect_pwm(0, "R4");
    below_low[0] = 1'b0;

    // R10: bring both into skip mode, then knock out only lane 1
    cur_over_enter[1] = 1'b0; cur_over_leave[1] = 1'b0;
    steps(HOLD + 1);
    expect_pfm(0, 1'b0, "R10"); expect_pfm(1, 1'b0, "R10");
    below_low[1] = 1'b1;
    step();
    expect_pwm(1, "R10"); expect_pfm(0, 1'b0, "R10");
    below_low[1] = 1'b0;
    steps(HOLD + 1);
    expect_pfm(1, 1'b0, "R10");

    // R8: force during a burst
    above_skip[0] = 1'b0;
    step();
    expect_pfm(0, 1'b1, "R5");
    force_pwm = 1'b1;
    step();
    expect_pwm(0, "R8"); expect_pwm(1, "R8");
    above_skip[0] = 1'b1;
    steps(3);
    expect_pwm(0, "R8"); expect_pwm(1, "R8");

    // R9: release waits for the tick count
    force_pwm = 1'b0;
    steps(10);
    expect_pwm(0, "R9"); expect_pwm(1, "R9");
    for (int k = 0; k < REL; k++) begin
      us_tick = 1'b1;
      step();
      expect_pwm(0, "R9");
      us_tick = 1'b0;
      if (k < REL - 1) step();
    end
    step();
    expect_pfm(0, 1'b0, "R9"); expect_pfm(1, 1'b0, "R9");

    steps(2);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule